// File: doc/BRIEF.md
# Programmable Third-Order CIC Decimator

This block turns a 1-bit oversampled bitstream into 17-bit words at a lower rate. The decimation ratio M can be set to 64, 128 or 256 while the block runs. Three integrators are updated on each accepted input sample. On every M-th accepted sample, the value of the last integrator is captured. A comb section then takes three successive differences of the captured value. That section uses one shared subtractor over three clock cycles, so it runs at the decimated rate.

All state is 25 bits wide for every ratio, which is the width the largest ratio needs. Sums and differences wrap modulo 2^25, and the wrap of the integrators cancels in the comb. A 17-bit window is taken from the final difference at a position set by M, and a one-cycle strobe marks each new word. The input bit is read as unsigned 0 or 1. The output therefore runs from 0 (all zeros) to 65536 (all ones), with 32768 meaning a balanced stream.

Top module: `cic_decimator`

## Requirements
- R1: While `rst` is high, and in the cycle after `rst` is sampled high, `outValid` is 0. `outData` reads 0 after reset until the first word. All filter state is cleared.
- R2: `ratioSel` selects M as follows: 0 gives M=64, 1 gives M=128, and 2 or 3 gives M=256. The output word is bits [18:2] of the final 25-bit difference for M=64, bits [21:5] for M=128 and bits [24:8] for M=256. For a 1010... stream in steady state, the output is 32768.
- R3: For each accepted sample x, the integrators update together as a1 += x, a2 += old a1 and a3 += old a2. On the M-th accepted sample since the last clear, the new value of a3 is captured.
- R4: Each captured value s goes through three differences: d1 = s - c1, d2 = d1 - c2 and d3 = d2 - c3. The delays then take c1 = s, c2 = d1 and c3 = d2. `outValid` is high on the third clock edge after the edge that accepts the M-th sample.
- R5: All arithmetic wraps modulo 2^25 without saturation. An all-ones input settles to exactly 65536 and an all-zeros input settles to 0, for every M.
- R6: A cycle with `inValid` low has no effect on the output, whatever `inBit` is.
- R7: A change of `ratioSel` clears all integrator, comb-delay, capture and sample-count state, and any comb work in progress. No output appears in the next cycle. The first new word comes only after M new accepted samples.
- R8: `outValid` is high for one cycle at a time, and `outData` holds its value between strobes.
- R9: Two strobes, or a clear and the following strobe, are always at least 64 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ratioSel | input | 2 | Decimation ratio select (0:64, 1:128, 2/3:256) |
| inValid | input | 1 | Qualifies `inBit` as a new sample |
| inBit | input | 1 | Bitstream input, unsigned 0/1 |
| outData | output | 17 | Decimated output word |
| outValid | output | 1 | One-cycle strobe for a new `outData` |

## Verification
The assertions check on every cycle that the strobe lasts one cycle and that the word holds between strobes. They also check that reset and a ratio change suppress the strobe in the next cycle, and that strobes keep the minimum spacing. The numeric behaviour can only be shown by the bench's scenarios. That covers the integrator recurrence, the wrap-around cancellation, the window position for each ratio, the latency of the serial comb, and the restart after a ratio change in mid-frame. The bench compares every word against a model of the recurrences in R3 and R4, and applies directed steady-state checks.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int CIC_ORDER = 3;
  localparam int STEP_W = $clog2(CIC_ORDER);

  typedef struct packed {
    logic              clr;
    logic              accept;
    logic              snap;
    logic              stepEn;
    logic [STEP_W-1:0] step;
    logic              finish;
  } ctrlStrobe_t;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int LOG2_MIN   = 6,
  parameter int NUM_RATIOS = 3,
  localparam int SELW      = $clog2(NUM_RATIOS),
  localparam int CNTW      = LOG2_MIN + NUM_RATIOS - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] ratioSel,
  input  logic            inValid,
  output ctrlStrobe_t     strobe
);
  logic [SELW-1:0]   ratioQ;
  logic [SELW-1:0]   selIdx;
  logic [CNTW-1:0]   cnt;
  logic [CNTW-1:0]   cntLimit;
  logic              busy;
  logic [STEP_W-1:0] phase;
  logic              clr;
  logic              accept;
  logic              snap;

  always_comb begin
    selIdx   = (ratioSel > SELW'(NUM_RATIOS - 1)) ? SELW'(NUM_RATIOS - 1) : ratioSel;
    cntLimit = CNTW'((1 << (LOG2_MIN + int'(selIdx))) - 1);
    clr      = rst || (ratioSel != ratioQ);
    accept   = inValid && !clr;
    snap     = accept && (cnt == cntLimit);
  end

  always_ff @(posedge clk) begin
    ratioQ <= ratioSel;
    if (clr) begin
      cnt   <= '0;
      busy  <= 1'b0;
      phase <= '0;
    end else begin
      if (accept) cnt <= (cnt == cntLimit) ? '0 : cnt + 1'b1;
      if (snap) begin
        busy  <= 1'b1;
        phase <= '0;
      end else if (busy) begin
        if (phase == STEP_W'(CIC_ORDER - 1)) busy <= 1'b0;
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clr    = clr;
    strobe.accept = accept;
    strobe.snap   = snap;
    strobe.stepEn = busy && !clr;
    strobe.step   = phase;
    strobe.finish = busy && !clr && (phase == STEP_W'(CIC_ORDER - 1));
  end
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int LOG2_MIN   = 6,
  parameter int NUM_RATIOS = 3,
  parameter int OUTW       = 17,
  localparam int SELW      = $clog2(NUM_RATIOS),
  localparam int W         = 1 + CIC_ORDER * (LOG2_MIN + NUM_RATIOS - 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] ratioSel,
  input  logic            inBit,
  input  ctrlStrobe_t     strobe,
  output logic [OUTW-1:0] outData,
  output logic            outValid
);
  localparam int TOP_LSB = W - OUTW;

  logic [W-1:0] integ     [CIC_ORDER];
  logic [W-1:0] integNext [CIC_ORDER];
  logic [W-1:0] combDly   [CIC_ORDER];
  logic [W-1:0] snapReg;
  logic [W-1:0] work;
  logic [W-1:0] minuend;
  logic [W-1:0] subtr;
  logic [W-1:0] diff;
  logic [W-1:0] shifted;
  logic [SELW-1:0] selIdx;
  int lsbPos;

  for (genvar k = 0; k < CIC_ORDER; k++) begin : g_integ
    if (k == 0) begin : g_first
      assign integNext[k] = integ[k] + W'(inBit);
    end else begin : g_rest
      assign integNext[k] = integ[k] + integ[k-1];
    end
    always_ff @(posedge clk) begin
      if (strobe.clr) integ[k] <= '0;
      else if (strobe.accept) integ[k] <= integNext[k];
    end
  end

  for (genvar k = 0; k < CIC_ORDER; k++) begin : g_comb
    always_ff @(posedge clk) begin
      if (strobe.clr) combDly[k] <= '0;
      else if (strobe.stepEn && strobe.step == STEP_W'(k)) combDly[k] <= minuend;
    end
  end

  always_comb begin
    minuend = (strobe.step == '0) ? snapReg : work;
    subtr = '0;
    for (int k = 0; k < CIC_ORDER; k++) begin
      if (strobe.step == STEP_W'(k)) subtr = combDly[k];
    end
    diff    = minuend - subtr;
    selIdx  = (ratioSel > SELW'(NUM_RATIOS - 1)) ? SELW'(NUM_RATIOS - 1) : ratioSel;
    lsbPos  = TOP_LSB - (NUM_RATIOS - 1 - int'(selIdx)) * CIC_ORDER;
    shifted = diff >> lsbPos;
  end

  always_ff @(posedge clk) begin
    if (strobe.clr) begin
      snapReg <= '0;
      work    <= '0;
    end else begin
      if (strobe.snap) snapReg <= integNext[CIC_ORDER-1];
      if (strobe.stepEn) work <= diff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.finish;
      if (strobe.finish) outData <= shifted[OUTW-1:0];
    end
  end
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int LOG2_MIN   = 6,
  parameter int NUM_RATIOS = 3,
  parameter int OUTW       = 17
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [$clog2(NUM_RATIOS)-1:0] ratioSel,
  input  logic                          inValid,
  input  logic                          inBit,
  output logic [OUTW-1:0]               outData,
  output logic                          outValid
);
  ctrlStrobe_t strobe;

  cic_ctrl #(.LOG2_MIN(LOG2_MIN), .NUM_RATIOS(NUM_RATIOS)) u_ctrl (
    .clk(clk), .rst(rst), .ratioSel(ratioSel), .inValid(inValid), .strobe(strobe)
  );

  cic_datapath #(.LOG2_MIN(LOG2_MIN), .NUM_RATIOS(NUM_RATIOS), .OUTW(OUTW)) u_dp (
    .clk(clk), .rst(rst), .ratioSel(ratioSel), .inBit(inBit), .strobe(strobe),
    .outData(outData), .outValid(outValid)
  );
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int LOG2_MIN = 6,
  parameter int SELW     = 2,
  parameter int OUTW     = 17
) (
  input logic            clk,
  input logic            rst,
  input logic [SELW-1:0] ratioSel,
  input logic [OUTW-1:0] outData,
  input logic            outValid
);
  localparam int MIN_M = 1 << LOG2_MIN;
  localparam int GAPW  = LOG2_MIN + 1;

  logic [SELW-1:0] ratioPrev;
  logic [GAPW-1:0] gap;
  logic            armed;
  logic            ratioChg;

  assign ratioChg = (ratioSel != ratioPrev);

  always_ff @(posedge clk) begin
    ratioPrev <= ratioSel;
    if (rst) begin
      armed <= 1'b0;
      gap   <= '0;
    end else begin
      armed <= 1'b1;
      if (ratioChg || outValid) gap <= '0;
      else if (gap != {GAPW{1'b1}}) gap <= gap + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!outValid && outData == '0));

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !outValid) |-> $stable(outData));

  // R7
  ratio_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ratioChg |=> !outValid);

  // R9
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && outValid) |-> (int'(gap) >= MIN_M - 1));
endmodule

bind cic_decimator cic_checker #(
  .LOG2_MIN(LOG2_MIN), .SELW($clog2(NUM_RATIOS)), .OUTW(OUTW)
) u_cic_checker (
  .clk(clk), .rst(rst), .ratioSel(ratioSel), .outData(outData), .outValid(outValid)
);

// File: tb/cic_decimator_bench.sv
module cic_decimator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ratioSel = 2'd0;
  logic        inValid = 1'b0;
  logic        inBit = 1'b0;
  logic [16:0] outData;
  logic        outValid;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  bit running = 1'b0;

  logic [24:0] mi [3];
  logic [24:0] mc [3];
  int mcnt = 0;
  int mM = 64;
  int mLsb = 2;
  logic [16:0] expQ [$];
  int cycQ [$];
  logic [16:0] lastOut = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  cic_decimator u_cic_decimator (
    .clk(clk), .rst(rst), .ratioSel(ratioSel), .inValid(inValid), .inBit(inBit),
    .outData(outData), .outValid(outValid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratioOf(input logic [1:0] s);
    return (s == 2'd0) ? 64 : (s == 2'd1) ? 128 : 256;
  endfunction

  function automatic int lsbOf(input int m);
    return (m == 64) ? 2 : (m == 128) ? 5 : 8;
  endfunction

  task automatic modelClear();
    for (int k = 0; k < 3; k++) begin
      mi[k] = '0;
      mc[k] = '0;
    end
    mcnt = 0;
    mM = ratioOf(ratioSel);
    mLsb = lsbOf(mM);
    expQ.delete();
    cycQ.delete();
  endtask

  task automatic modelSample(input bit b);
    logic [24:0] n0, n1, n2, d1, d2, d3, sh;
    n0 = mi[0] + 25'(b);
    n1 = mi[1] + mi[0];
    n2 = mi[2] + mi[1];
    mi[0] = n0; mi[1] = n1; mi[2] = n2;
    mcnt++;
    if (mcnt == mM) begin
      mcnt = 0;
      d1 = n2 - mc[0];
      d2 = d1 - mc[1];
      d3 = d2 - mc[2];
      mc[0] = n2; mc[1] = d1; mc[2] = d2;
      sh = d3 >> mLsb;
      expQ.push_back(sh[16:0]);
      cycQ.push_back(cycle + 4);
    end
  endtask

  task automatic step(input bit v, input bit b);
    @(negedge clk);
    inValid = v;
    inBit = b;
    if (v) modelSample(b);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0);
  endtask

  // mode 0 ones, 1 zeros, 2 alternating, 3 random with gaps
  task automatic run(input int nValid, input int mode);
    int done = 0;
    int ph = 0;
    while (done < nValid) begin
      bit v, b;
      v = 1'b1;
      b = 1'b0;
      case (mode)
        0: b = 1'b1;
        1: b = 1'b0;
        2: begin b = ph[0]; ph++; end
        default: begin
          v = ($urandom % 4) != 0;
          b = $urandom % 2;
        end
      endcase
      step(v, b);
      if (v) done++;
    end
  endtask

  task automatic setRatio(input logic [1:0] s);
    @(negedge clk);
    ratioSel = s;
    inValid = 1'b0;
    modelClear();
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    chk(outData == '0, "R1 outData in reset", int'(outData), 0);
    rst = 1'b0;
    modelClear();
  endtask

  always @(negedge clk) begin
    if (running && !rst && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected output word", int'(outData), -1);
      end else begin
        logic [16:0] e;
        int ec;
        e = expQ.pop_front();
        ec = cycQ.pop_front();
        chk(outData == e, "R3 R4 output word", int'(outData), int'(e));
        chk(cycle == ec, "R4 output latency", cycle, ec);
      end
      lastOut = outData;
    end
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    running = 1'b1;
    doReset();

    for (int s = 0; s < 3; s++) begin
      setRatio(2'(s));
      run(5 * mM, 0);
      drain();
      chk(lastOut == 17'd65536, "R5 all ones full scale", int'(lastOut), 65536);
      run(5 * mM, 1);
      drain();
      chk(lastOut == 17'd0, "R5 all zeros", int'(lastOut), 0);
      run(5 * mM, 2);
      drain();
      chk(lastOut == 17'd32768, "R2 mid-scale window", int'(lastOut), 32768);
      run(6 * mM, 3);
      drain();
      chk(expQ.size() == 0, "R6 random stream all words seen", expQ.size(), 0);
    end

    // R2 encoding 3 acts as 256
    setRatio(2'd3);
    run(5 * 256, 0);
    drain();
    chk(lastOut == 17'd65536, "R2 select 3 full scale", int'(lastOut), 65536);
    run(3 * 256, 3);
    drain();

    // R7 ratio change in mid-frame
    setRatio(2'd0);
    run(100, 3);
    drain();
    setRatio(2'd1);
    run(127, 0);
    drain();
    chk(expQ.size() == 0, "R7 no word before M samples", expQ.size(), 0);
    run(4 * 128 + 1, 3);
    drain();

    // R1 reset in mid-frame
    run(50, 0);
    doReset();
    run(5 * 128, 0);
    drain();
    chk(lastOut == 17'd65536, "R1 restart after reset", int'(lastOut), 65536);

    chk(expQ.size() == 0, "R4 pending words", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule